// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the arithmetic and shift stage of a three-operand load/store RISC pipeline. It is purely combinational. It receives the two register operands, a 16-bit immediate, a 5-bit fixed shift count, a 6-bit selector and a mode flag. In the same cycle it returns a 32-bit result and a flag that marks an unsupported operation. The surrounding pipeline registers the result and the flag.

The mode flag tells the block how to read the selector. When the flag is low, the selector is the function field of a register-register instruction, and the second operand is `rt_val`. When the flag is high, the selector is the major opcode of an immediate instruction, and the immediate takes the place of `rt_val`. Arithmetic immediates are sign-extended and logical immediates are zero-extended. Add and subtract wrap modulo 2^32 and never trap.

Top module: `risc_exec_alu`

## Requirements
- R1: With register mode and selector 100000 the result is `rs_val + rt_val`. With selector 100010 it is `rs_val - rt_val`. Both wrap modulo 2^32.
- R2: In register mode, selectors 100100, 100101, 100110 and 100111 give the bitwise AND, OR, XOR and NOR of `rs_val` and `rt_val`. NOR of a value with itself gives its bitwise complement.
- R3: In register mode, selectors 000000, 000010 and 000011 shift `rt_val` left logically, right logically and right arithmetically by `shamt`. `rs_val` has no effect on these three.
- R4: In register mode, selectors 000100, 000110 and 000111 perform the same three shifts on `rt_val`. The count is taken from `rs_val[4:0]`. The upper bits of `rs_val` and the `shamt` port have no effect.
- R5: Arithmetic right shifts fill the vacated bits with copies of `rt_val[31]`. Logical right shifts and all left shifts fill the vacated bits with zeros. A count of 0 passes `rt_val` through unchanged.
- R6: In register mode, selector 101010 compares `rs_val < rt_val` as signed values and selector 101011 compares them as unsigned values. The result is exactly 0x00000001 when the comparison is true and 0x00000000 when it is false.
- R7: In immediate mode, selectors 001000 (add), 001001 (add, unsigned name), 001010 (signed less-than) and 001011 (unsigned less-than) sign-extend `imm` to 32 bits before using it as the second operand.
- R8: In immediate mode, selectors 001100, 001101 and 001110 (AND, OR, XOR) zero-extend `imm` to 32 bits before using it as the second operand.
- R9: Any selector not listed above, in either mode, drives `result` to 0 and `illegal` to 1. Every listed selector drives `illegal` to 0.
- R10: The outputs depend only on the present inputs, with no clock and no stored state. In immediate mode `rt_val` has no effect on the outputs. In register mode `imm` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_val | input | 32 | First source operand; its low bits supply the count for variable shifts |
| rt_val | input | 32 | Second source operand in register mode; the value that every shift moves |
| imm | input | 16 | Immediate field, extended according to the operation |
| shamt | input | 5 | Shift count for the fixed-count shifts |
| sel | input | 6 | Function field in register mode, major opcode in immediate mode |
| imm_mode | input | 1 | 1 selects the immediate forms and the immediate operand |
| result | output | 32 | Operation result |
| illegal | output | 1 | High when `sel` names no supported operation in the current mode |

## Verification
The block holds no state, so any internal fault appears at `result` or `illegal` in the same cycle as the input that provokes it. A decode mistake can pick the wrong extension rule, the wrong count source or the wrong fill bit. Such a mistake shows only for particular operand values: a negative immediate, `rs_val` bits set above bit 4, or a negative `rt_val`. The vectors are therefore chosen so that each of these wrong choices produces a result that differs from the correct one.

// File: rtl/risc_exec_alu.sv
module risc_exec_alu #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SEL_W = 6,
  parameter int SHW   = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [SHW-1:0]   shamt,
  input  logic [SEL_W-1:0] sel,
  input  logic             imm_mode,
  output logic [XLEN-1:0]  result,
  output logic             illegal
);

  localparam logic [SEL_W-1:0] F_SLL  = 6'b000000;
  localparam logic [SEL_W-1:0] F_SRL  = 6'b000010;
  localparam logic [SEL_W-1:0] F_SRA  = 6'b000011;
  localparam logic [SEL_W-1:0] F_SLLV = 6'b000100;
  localparam logic [SEL_W-1:0] F_SRLV = 6'b000110;
  localparam logic [SEL_W-1:0] F_SRAV = 6'b000111;
  localparam logic [SEL_W-1:0] F_ADD  = 6'b100000;
  localparam logic [SEL_W-1:0] F_SUB  = 6'b100010;
  localparam logic [SEL_W-1:0] F_AND  = 6'b100100;
  localparam logic [SEL_W-1:0] F_OR   = 6'b100101;
  localparam logic [SEL_W-1:0] F_XOR  = 6'b100110;
  localparam logic [SEL_W-1:0] F_NOR  = 6'b100111;
  localparam logic [SEL_W-1:0] F_SLT  = 6'b101010;
  localparam logic [SEL_W-1:0] F_SLTU = 6'b101011;

  localparam logic [SEL_W-1:0] O_ADDI  = 6'b001000;
  localparam logic [SEL_W-1:0] O_ADDIU = 6'b001001;
  localparam logic [SEL_W-1:0] O_SLTI  = 6'b001010;
  localparam logic [SEL_W-1:0] O_SLTIU = 6'b001011;
  localparam logic [SEL_W-1:0] O_ANDI  = 6'b001100;
  localparam logic [SEL_W-1:0] O_ORI   = 6'b001101;
  localparam logic [SEL_W-1:0] O_XORI  = 6'b001110;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA, OP_BAD
  } op_e;

  op_e             op;
  logic            zext_imm;
  logic            var_count;
  logic [XLEN-1:0] opb;
  logic [SHW-1:0]  count;
  logic            lt_s, lt_u;

  always_comb begin
    op        = OP_BAD;
    zext_imm  = 1'b0;
    var_count = 1'b0;
    if (!imm_mode) begin
      case (sel)
        F_SLL:  op = OP_SLL;
        F_SRL:  op = OP_SRL;
        F_SRA:  op = OP_SRA;
        F_SLLV: begin op = OP_SLL; var_count = 1'b1; end
        F_SRLV: begin op = OP_SRL; var_count = 1'b1; end
        F_SRAV: begin op = OP_SRA; var_count = 1'b1; end
        F_ADD:  op = OP_ADD;
        F_SUB:  op = OP_SUB;
        F_AND:  op = OP_AND;
        F_OR:   op = OP_OR;
        F_XOR:  op = OP_XOR;
        F_NOR:  op = OP_NOR;
        F_SLT:  op = OP_SLT;
        F_SLTU: op = OP_SLTU;
        default: op = OP_BAD;
      endcase
    end else begin
      case (sel)
        O_ADDI, O_ADDIU: op = OP_ADD;
        O_SLTI:  op = OP_SLT;
        O_SLTIU: op = OP_SLTU;
        O_ANDI:  begin op = OP_AND; zext_imm = 1'b1; end
        O_ORI:   begin op = OP_OR;  zext_imm = 1'b1; end
        O_XORI:  begin op = OP_XOR; zext_imm = 1'b1; end
        default: op = OP_BAD;
      endcase
    end
  end

  assign opb   = !imm_mode ? rt_val
               : zext_imm  ? {{(XLEN-IMM_W){1'b0}}, imm}
               :             {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign count = var_count ? rs_val[SHW-1:0] : shamt;
  assign lt_s  = $signed(rs_val) < $signed(opb);
  assign lt_u  = rs_val < opb;

  always_comb begin
    case (op)
      OP_ADD:  result = rs_val + opb;
      OP_SUB:  result = rs_val - opb;
      OP_AND:  result = rs_val & opb;
      OP_OR:   result = rs_val | opb;
      OP_XOR:  result = rs_val ^ opb;
      OP_NOR:  result = ~(rs_val | opb);
      OP_SLT:  result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLL:  result = rt_val << count;
      OP_SRL:  result = rt_val >> count;
      OP_SRA:  result = XLEN'($signed(rt_val) >>> count);
      default: result = '0;
    endcase
  end

  assign illegal = (op == OP_BAD);

  always_comb begin
    if (illegal)
      assert_illegal_zero_R9: assert (result == '0)
        else $error("illegal selector gave nonzero result");
    if (!imm_mode && sel == F_SUB)
      assert_sub_inverse_R1: assert (result + rt_val == rs_val)
        else $error("subtract does not invert add");
    if (!imm_mode && sel == F_NOR && rs_val == rt_val)
      assert_nor_self_R2: assert (result == ~rs_val)
        else $error("self NOR is not complement");
    if (!imm_mode && (sel == F_SRA || sel == F_SRAV))
      assert_sra_sign_R5: assert (result[XLEN-1] == rt_val[XLEN-1])
        else $error("arithmetic shift lost sign");
    if (!imm_mode && sel == F_SRL && shamt != '0)
      assert_srl_fill_R5: assert (!result[XLEN-1])
        else $error("logical shift filled with one");
    if (!imm_mode && (sel == F_SLT || sel == F_SLTU))
      assert_bool_result_R6: assert (result[XLEN-1:1] == '0)
        else $error("compare result not boolean");
    if (imm_mode && sel == O_ANDI)
      assert_andi_zext_R8: assert (result[XLEN-1:IMM_W] == '0)
        else $error("ANDI upper half not cleared");
    if (imm_mode && sel == O_ORI)
      assert_ori_keep_R8: assert (result[XLEN-1:IMM_W] == rs_val[XLEN-1:IMM_W])
        else $error("ORI altered upper half");
  end

endmodule

// File: tb/risc_exec_alu_bench.sv
module risc_exec_alu_bench;
  logic        clk = 1'b0;
  logic [31:0] rs_val, rt_val;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [5:0]  sel;
  logic        imm_mode;
  logic [31:0] result;
  logic        illegal;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  risc_exec_alu u_risc_exec_alu (
    .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .shamt(shamt),
    .sel(sel), .imm_mode(imm_mode), .result(result), .illegal(illegal)
  );

  // {req, imm_mode, sel, rs, rt, imm, shamt, expected result, expected illegal}
  localparam int NV = 40;
  localparam logic [128:0] VEC [NV] = '{
    // R1 add / subtract with wrap
    {4'd1, 1'b0, 6'b100000, 32'h7FFFFFFF, 32'h00000001, 16'h0000, 5'd0, 32'h80000000, 1'b0},
    {4'd1, 1'b0, 6'b100000, 32'hFFFFFFFF, 32'h00000002, 16'h0000, 5'd0, 32'h00000001, 1'b0},
    {4'd1, 1'b0, 6'b100010, 32'h00000005, 32'h00000007, 16'h0000, 5'd0, 32'hFFFFFFFE, 1'b0},
    {4'd1, 1'b0, 6'b100010, 32'h00000010, 32'h00000003, 16'h0000, 5'd0, 32'h0000000D, 1'b0},
    // R2 bitwise logic
    {4'd2, 1'b0, 6'b100100, 32'h000000F0, 32'h0000003C, 16'h0000, 5'd0, 32'h00000030, 1'b0},
    {4'd2, 1'b0, 6'b100101, 32'h000000F0, 32'h0000003C, 16'h0000, 5'd0, 32'h000000FC, 1'b0},
    {4'd2, 1'b0, 6'b100110, 32'h000000F0, 32'h0000003C, 16'h0000, 5'd0, 32'h000000CC, 1'b0},
    {4'd2, 1'b0, 6'b100111, 32'h000000F0, 32'h0000003C, 16'h0000, 5'd0, 32'hFFFFFF03, 1'b0},
    {4'd2, 1'b0, 6'b100111, 32'h000000F0, 32'h000000F0, 16'h0000, 5'd0, 32'hFFFFFF0F, 1'b0},
    // R3 fixed-count shifts, rs ignored
    {4'd3, 1'b0, 6'b000000, 32'hDEADBEEF, 32'h8000000F, 16'h0000, 5'd4, 32'h000000F0, 1'b0},
    {4'd3, 1'b0, 6'b000010, 32'h00000000, 32'h80000000, 16'h0000, 5'd7, 32'h01000000, 1'b0},
    {4'd3, 1'b0, 6'b000011, 32'h00000000, 32'hFFFFFFF0, 16'h0000, 5'd2, 32'hFFFFFFFC, 1'b0},
    {4'd3, 1'b0, 6'b000010, 32'hFFFFFFFF, 32'h00000100, 16'h0000, 5'd8, 32'h00000001, 1'b0},
    // R5 fill rules and zero count
    {4'd5, 1'b0, 6'b000011, 32'h00000000, 32'h80000000, 16'h0000, 5'd31, 32'hFFFFFFFF, 1'b0},
    {4'd5, 1'b0, 6'b000010, 32'h00000000, 32'h80000000, 16'h0000, 5'd31, 32'h00000001, 1'b0},
    {4'd5, 1'b0, 6'b000000, 32'h00000000, 32'h12345678, 16'h0000, 5'd0, 32'h12345678, 1'b0},
    {4'd5, 1'b0, 6'b000000, 32'h00000000, 32'hFFFFFFFF, 16'h0000, 5'd31, 32'h80000000, 1'b0},
    // R4 variable shifts: count = rs[4:0], shamt ignored
    {4'd4, 1'b0, 6'b000100, 32'hFFFFFFE5, 32'h00000001, 16'h0000, 5'd31, 32'h00000020, 1'b0},
    {4'd4, 1'b0, 6'b000110, 32'h00000024, 32'hF0000000, 16'h0000, 5'd1, 32'h0F000000, 1'b0},
    {4'd4, 1'b0, 6'b000111, 32'h00000020, 32'h80000001, 16'h0000, 5'd9, 32'h80000001, 1'b0},
    {4'd4, 1'b0, 6'b000111, 32'h00000003, 32'h8000000C, 16'h0000, 5'd0, 32'hF0000001, 1'b0},
    // R6 set-less-than
    {4'd6, 1'b0, 6'b101010, 32'hFFFFFFFF, 32'h00000000, 16'h0000, 5'd0, 32'h00000001, 1'b0},
    {4'd6, 1'b0, 6'b101011, 32'hFFFFFFFF, 32'h00000000, 16'h0000, 5'd0, 32'h00000000, 1'b0},
    {4'd6, 1'b0, 6'b101010, 32'h00000003, 32'h00000003, 16'h0000, 5'd0, 32'h00000000, 1'b0},
    {4'd6, 1'b0, 6'b101010, 32'h000000FF, 32'hFFFFFFFF, 16'h0000, 5'd0, 32'h00000000, 1'b0},
    {4'd6, 1'b0, 6'b101011, 32'h000000FF, 32'hFFFFFFFF, 16'h0000, 5'd0, 32'h00000001, 1'b0},
    // R7 sign-extended immediates
    {4'd7, 1'b1, 6'b001000, 32'h00000005, 32'h00000000, 16'hFFFF, 5'd0, 32'h00000004, 1'b0},
    {4'd7, 1'b1, 6'b001001, 32'h00000010, 32'h00000000, 16'h8000, 5'd0, 32'hFFFF8010, 1'b0},
    {4'd7, 1'b1, 6'b001010, 32'h00000000, 32'h00000000, 16'h0023, 5'd0, 32'h00000001, 1'b0},
    {4'd7, 1'b1, 6'b001010, 32'h000000FF, 32'h00000000, 16'hFFF9, 5'd0, 32'h00000000, 1'b0},
    {4'd7, 1'b1, 6'b001011, 32'h00001000, 32'h00000000, 16'hFFFF, 5'd0, 32'h00000001, 1'b0},
    // R8 zero-extended immediates
    {4'd8, 1'b1, 6'b001100, 32'hFFFFFFFF, 32'h00000000, 16'h8001, 5'd0, 32'h00008001, 1'b0},
    {4'd8, 1'b1, 6'b001101, 32'h0000000E, 32'h00000000, 16'hFFFC, 5'd0, 32'h0000FFFE, 1'b0},
    {4'd8, 1'b1, 6'b001101, 32'h12340000, 32'h00000000, 16'h8000, 5'd0, 32'h12348000, 1'b0},
    {4'd8, 1'b1, 6'b001110, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 5'd0, 32'hFFFF0000, 1'b0},
    // R9 undefined selectors
    {4'd9, 1'b0, 6'b000001, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd3, 32'h00000000, 1'b1},
    {4'd9, 1'b0, 6'b111111, 32'h12345678, 32'h9ABCDEF0, 16'h1234, 5'd0, 32'h00000000, 1'b1},
    {4'd9, 1'b1, 6'b000000, 32'h00000001, 32'h00000001, 16'h0001, 5'd0, 32'h00000000, 1'b1},
    // R10 unused operand has no effect
    {4'd10, 1'b1, 6'b001000, 32'h00000001, 32'hFFFFFFFF, 16'h0001, 5'd0, 32'h00000002, 1'b0},
    {4'd10, 1'b0, 6'b100000, 32'h00000001, 32'h00000001, 16'hFFFF, 5'd31, 32'h00000002, 1'b0}
  };

  task automatic check(input int req, input logic [31:0] exp, input logic exp_ill, input string tag);
    n_cmp++;
    if (result !== exp || illegal !== exp_ill) begin
      n_bad++;
      $display("FAIL R%0d %s: got result=%h illegal=%b, expected result=%h illegal=%b",
               req, tag, result, illegal, exp, exp_ill);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    rs_val = '0; rt_val = '0; imm = '0; shamt = '0; sel = '0; imm_mode = 1'b0;
    @(negedge clk); #1;
    check(3, 32'h0, 1'b0, "idle all-zero inputs");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      imm_mode = VEC[i][124];
      sel      = VEC[i][123:118];
      rs_val   = VEC[i][117:86];
      rt_val   = VEC[i][85:54];
      imm      = VEC[i][53:38];
      shamt    = VEC[i][37:33];
      #1;
      check(int'(VEC[i][128:125]), VEC[i][32:1], VEC[i][0], $sformatf("vector %0d", i));
    end

    // R10: output follows input within the same cycle, no edge needed
    @(negedge clk);
    imm_mode = 1'b0; sel = 6'b100000; rs_val = 32'd10; rt_val = 32'd20; imm = '0; shamt = '0;
    #1; check(10, 32'd30, 1'b0, "before mid-cycle change");
    rt_val = 32'd5;
    #0.5; check(10, 32'd15, 1'b0, "after mid-cycle change");

    // R10: immediate mode ignores rt_val across several values
    @(negedge clk);
    imm_mode = 1'b1; sel = 6'b001101; rs_val = 32'hA0000000; imm = 16'h00FF; rt_val = 32'h0;
    #1; check(10, 32'hA00000FF, 1'b0, "ORI rt zero");
    rt_val = 32'hFFFFFFFF;
    #1; check(10, 32'hA00000FF, 1'b0, "ORI rt ones");

    // R9: switching mode turns a valid function code into an undefined opcode
    @(negedge clk);
    imm_mode = 1'b1; sel = 6'b100000;
    #1; check(9, 32'h0, 1'b1, "ADD code in immediate mode");
    imm_mode = 1'b0; sel = 6'b001000;
    #1; check(9, 32'h0, 1'b1, "ADDI code in register mode");

    done = 1'b1;
    finish_run();
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog expired: got no completion, expected completion");
      finish_run();
    end
  end
endmodule